// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small single-accumulator processor. It holds three architectural registers: a program counter, an instruction register and an accumulator. It runs a loop with two phases. First it reads the 16-bit word at the program counter into the instruction register. Then it carries out that instruction. The loop repeats until a halt is executed.

Only three operations move data: load the accumulator from memory, store it to memory, and add a memory word into it. All integers are sign-magnitude. The top bit is the sign and the other fifteen bits hold the magnitude.

The core drives a synchronous, word-addressed memory port. Every read returns its data one cycle after the address is presented, so each memory read costs a wait cycle. The accumulator, program counter, instruction register and status flags are brought out as outputs. A system can therefore inspect the finished state once the core stops.

Top module: `acc_core`

## Requirements
- R1: While reset is held, the core shows pc_out = START_ADDR, ir_out = 0, ac_out = 0, with halted, illegal, overflow and mem_we all low.
- R2: Each instruction starts with a fetch cycle that drives mem_addr = PC. The next cycle is a wait cycle, and at its end the instruction register captures mem_rdata. Execution follows in the cycle after that.
- R3: An instruction word holds the opcode in bits [15:12] and the operand address in bits [11:0]. Opcode 1 (load) reads the word at the address field, using one wait cycle, and copies it into the accumulator. The whole instruction takes 4 cycles.
- R4: Opcode 2 (store) asserts mem_we for exactly one cycle, the execute cycle. In that cycle mem_addr equals the address field and mem_wdata equals the accumulator. A store takes 3 cycles.
- R5: Opcode 5 (add) reads the word at the address field and adds it to the accumulator as sign-magnitude values. When the two signs are equal, the magnitudes are summed and the sign is kept. The add takes 4 cycles.
- R6: When the two signs differ, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. A zero result is always 0x0000, never 0x8000.
- R7: If the sum of two magnitudes exceeds 15 bits, the magnitude wraps modulo 2^15 and overflow is set. Overflow stays set until reset.
- R8: After every completed load, store or add, the PC advances by one. It wraps from 4095 to 0.
- R9: Opcode 0 sets halted. After that, the PC stays at the halt instruction's address, no further memory write occurs, and every architectural output holds.
- R10: Any opcode other than 0, 1, 2 or 5 also halts the core and raises illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Word address for the memory |
| mem_wdata | output | 16 | Data written on a store |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an undefined opcode |
| overflow | output | 1 | Sticky magnitude overflow from an add |
| pc_out | output | 12 | Program counter |
| ir_out | output | 16 | Instruction register |
| ac_out | output | 16 | Accumulator, sign-magnitude |

## Verification
On every cycle the assertions check the following local properties:
- the write strobe lasts a single cycle;
- the instruction register captures the read word right after the wait cycle;
- each completed instruction advances the PC by exactly one;
- a load copies the read word;
- an add never yields negative zero;
- the overflow flag is sticky;
- an illegal stop is always a halted state that stays frozen.

Only the bench's programs can show that whole instruction sequences produce the right architectural results. Examples are mixed-sign sums that cancel to zero, a magnitude that wraps, stored words landing at the right addresses, and a PC that wraps across the top of the address space. The bench shows these by comparing every output against a behavioural model on every clock.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  // Core phase; the fetch/wait/execute order is the behaviour of the loop.
  typedef enum logic [2:0] {
    PH_FETCH,
    PH_FWAIT,
    PH_EXEC,
    PH_OWAIT,
    PH_HALT
  } phase_e;

  // What the accumulator does at the end of an operand wait cycle.
  typedef enum logic [1:0] {
    AC_KEEP,
    AC_LOAD,
    AC_ADD
  } ac_op_e;

  localparam int OP_HALT  = 0;
  localparam int OP_LOAD  = 1;
  localparam int OP_STORE = 2;
  localparam int OP_ADD   = 5;

endpackage

// File: rtl/acc_sm_adder.sv
module acc_sm_adder #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic              ovf
);

  localparam int MAG_W = DATA_W - 1;

  // Sign-magnitude addition; returns {overflow, sign, magnitude}.
  function automatic logic [DATA_W:0] sm_add(input logic [DATA_W-1:0] x,
                                             input logic [DATA_W-1:0] y);
    logic             sx, sy, sr, ov;
    logic [MAG_W-1:0] mx, my, mr;
    logic [MAG_W:0]   wide;
    sx = x[DATA_W-1];
    sy = y[DATA_W-1];
    mx = x[MAG_W-1:0];
    my = y[MAG_W-1:0];
    ov = 1'b0;
    if (sx == sy) begin
      wide = {1'b0, mx} + {1'b0, my};
      mr   = wide[MAG_W-1:0];
      ov   = wide[MAG_W];
      sr   = sx;
    end else if (mx >= my) begin
      mr = mx - my;
      sr = sx;
    end else begin
      mr = my - mx;
      sr = sy;
    end
    if (mr == '0) sr = 1'b0;
    return {ov, sr, mr};
  endfunction

  logic [DATA_W:0] res;

  always_comb begin
    res = sm_add(a, b);
    sum = res[DATA_W-1:0];
    ovf = res[DATA_W];
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ac_op_e            ac_op,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] ac,
  output logic              ovf
);

  localparam logic [DATA_W-1:0] NEG_ZERO = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] ac_q;
  logic              ovf_q;
  logic [DATA_W-1:0] add_sum;
  logic              add_ovf;

  acc_sm_adder #(.DATA_W(DATA_W)) u_adder (
    .a   (ac_q),
    .b   (mem_rdata),
    .sum (add_sum),
    .ovf (add_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      unique case (ac_op)
        AC_LOAD: ac_q <= mem_rdata;
        AC_ADD: begin
          ac_q  <= add_sum;
          ovf_q <= ovf_q | add_ovf;
        end
        default: ;
      endcase
    end
  end

  assign ac  = ac_q;
  assign ovf = ovf_q;

  // R3: a load copies the read word
  a_r3_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_op == AC_LOAD) |=> (ac_q == $past(mem_rdata)));

  // R6: add results are never negative zero
  a_r6_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_op == AC_ADD) |=> (ac_q != NEG_ZERO));

  // R7: overflow is sticky
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

endmodule

// File: rtl/acc_sequencer.sv
module acc_sequencer
  import acc_core_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                OPC_W      = 4,
  parameter logic [ADDR_W-1:0] START_ADDR = '0,
  localparam int               DATA_W     = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic              halted,
  output logic              illegal,
  output ac_op_e            ac_op
);

  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] ir_q, ir_d;
  logic              ill_q, ill_d;

  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] field;
  logic              is_halt, is_load, is_store, is_add;

  // Named internal events used by the assertions.
  logic              ir_load;
  logic              pc_step;
  logic              store_fire;

  assign opcode = ir_q[DATA_W-1 -: OPC_W];
  assign field  = ir_q[ADDR_W-1:0];

  assign is_halt  = (opcode == OPC_W'(OP_HALT));
  assign is_load  = (opcode == OPC_W'(OP_LOAD));
  assign is_store = (opcode == OPC_W'(OP_STORE));
  assign is_add   = (opcode == OPC_W'(OP_ADD));

  assign ir_load    = (phase_q == PH_FWAIT);
  assign store_fire = (phase_q == PH_EXEC) && is_store;
  assign pc_step    = store_fire || (phase_q == PH_OWAIT);

  always_comb begin
    phase_d = phase_q;
    ill_d   = ill_q;
    ir_d    = ir_q;
    pc_d    = pc_q;
    unique case (phase_q)
      PH_FETCH: phase_d = PH_FWAIT;
      PH_FWAIT: phase_d = PH_EXEC;
      PH_EXEC: begin
        if (is_store) begin
          phase_d = PH_FETCH;
        end else if (is_load || is_add) begin
          phase_d = PH_OWAIT;
        end else begin
          phase_d = PH_HALT;
          ill_d   = !is_halt;
        end
      end
      PH_OWAIT: phase_d = PH_FETCH;
      default:  phase_d = PH_HALT;
    endcase
    if (ir_load) ir_d = mem_rdata;
    if (pc_step) pc_d = pc_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= START_ADDR;
      ir_q    <= '0;
      ill_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pc_q    <= pc_d;
      ir_q    <= ir_d;
      ill_q   <= ill_d;
    end
  end

  always_comb begin
    ac_op = AC_KEEP;
    if (phase_q == PH_OWAIT) begin
      if (is_load)     ac_op = AC_LOAD;
      else if (is_add) ac_op = AC_ADD;
    end
  end

  assign mem_addr = (phase_q == PH_FETCH) ? pc_q : field;
  assign mem_we   = store_fire;
  assign pc       = pc_q;
  assign ir       = ir_q;
  assign halted   = (phase_q == PH_HALT);
  assign illegal  = ill_q;

  // R4: a write strobe lasts one cycle
  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R2: the instruction register captures the word read after the wait
  a_r2_ir_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> (ir_q == $past(mem_rdata)));

  // R8: each completed instruction advances the PC by one
  a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    pc_step |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

  // R9: a halted core stays frozen with no writes
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc_q) && $stable(ir_q) && !mem_we));

  // R10: an illegal opcode always means the core is halted
  a_r10_illegal_halts: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                OPC_W      = 4,
  parameter logic [ADDR_W-1:0] START_ADDR = '0,
  localparam int               DATA_W     = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic              illegal,
  output logic              overflow,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] ir_out,
  output logic [DATA_W-1:0] ac_out
);

  ac_op_e            ac_op;
  logic [DATA_W-1:0] ac;

  acc_sequencer #(
    .ADDR_W     (ADDR_W),
    .OPC_W      (OPC_W),
    .START_ADDR (START_ADDR)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .pc        (pc_out),
    .ir        (ir_out),
    .halted    (halted),
    .illegal   (illegal),
    .ac_op     (ac_op)
  );

  acc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ac_op     (ac_op),
    .mem_rdata (mem_rdata),
    .ac        (ac),
    .ovf       (overflow)
  );

  assign ac_out    = ac;
  assign mem_wdata = ac;

endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;

  localparam int          CLK_PERIOD = 10;
  localparam logic [11:0] START      = 12'hFFE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata = '0;
  logic        halted, illegal, overflow;
  logic [11:0] pc_out;
  logic [15:0] ir_out, ac_out;

  int errors = 0;
  int checks = 0;
  bit comparing = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core #(.START_ADDR(START)) u_acc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .halted    (halted),
    .illegal   (illegal),
    .overflow  (overflow),
    .pc_out    (pc_out),
    .ir_out    (ir_out),
    .ac_out    (ac_out)
  );

  // Memory seen by the core: registered read, one cycle latency.
  logic [15:0] mem [0:4095];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // Behavioural reference model with its own memory copy.
  logic [15:0] ref_mem [0:4095];
  int          m_ph;   // 0 fetch, 1 wait, 2 exec, 3 operand wait, 4 stopped
  logic [11:0] m_pc;
  logic [15:0] m_ir, m_ac;
  bit          m_ovf, m_halt, m_ill;

  function automatic logic [16:0] ref_add(input logic [15:0] x, input logic [15:0] y);
    int vx, vy, s, m;
    bit neg, ov;
    vx = x[15] ? -int'(x[14:0]) : int'(x[14:0]);
    vy = y[15] ? -int'(y[14:0]) : int'(y[14:0]);
    s   = vx + vy;
    neg = (s < 0);
    m   = neg ? -s : s;
    ov  = (m > 32767);
    m   = m % 32768;
    if (m == 0) neg = 1'b0;
    return {ov, neg, 15'(m)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_pc = START; m_ir = '0; m_ac = '0;
      m_ovf = 0; m_halt = 0; m_ill = 0;
    end else begin
      case (m_ph)
        0: m_ph = 1;
        1: begin m_ir = ref_mem[m_pc]; m_ph = 2; end
        2: begin
          case (m_ir[15:12])
            4'd2: begin ref_mem[m_ir[11:0]] = m_ac; m_pc = m_pc + 1; m_ph = 0; end
            4'd1, 4'd5: m_ph = 3;
            default: begin m_halt = 1; m_ill = (m_ir[15:12] != 0); m_ph = 4; end
          endcase
        end
        3: begin
          if (m_ir[15:12] == 4'd1) m_ac = ref_mem[m_ir[11:0]];
          else begin
            logic [16:0] r;
            r = ref_add(m_ac, ref_mem[m_ir[11:0]]);
            m_ac = r[15:0];
            m_ovf = m_ovf | r[16];
          end
          m_pc = m_pc + 1;
          m_ph = 0;
        end
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (comparing && rst_n) begin
      bit exp_we;
      exp_we = (m_ph == 2) && (m_ir[15:12] == 4'd2);
      chk("R8 pc", 32'(pc_out), 32'(m_pc));
      chk("R2 ir", 32'(ir_out), 32'(m_ir));
      chk("R5 ac", 32'(ac_out), 32'(m_ac));
      chk("R7 overflow", 32'(overflow), 32'(m_ovf));
      chk("R9 halted", 32'(halted), 32'(m_halt));
      chk("R10 illegal", 32'(illegal), 32'(m_ill));
      chk("R4 we", 32'(mem_we), 32'(exp_we));
      if (m_ph == 0) chk("R2 fetch addr", 32'(mem_addr), 32'(m_pc));
      if (exp_we) begin
        chk("R4 store addr", 32'(mem_addr), 32'(m_ir[11:0]));
        chk("R4 store data", 32'(mem_wdata), 32'(m_ac));
      end
    end
  end

  task automatic put(input logic [11:0] a, input logic [15:0] d);
    mem[a] = d;
    ref_mem[a] = d;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) begin
      mem[i] = '0;
      ref_mem[i] = '0;
    end
  endtask

  task automatic reset_core();
    comparing = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_until_halt();
    int n;
    n = 0;
    rst_n = 1'b1;
    comparing = 1'b1;
    while (!halted && n < 1000) begin
      @(negedge clk);
      n++;
    end
    if (!halted) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=halted");
    end
  endtask

  initial begin
    logic [11:0] pc_hold;
    clear_mem();
    repeat (2) @(negedge clk);

    // R1: reset state
    chk("R1 pc", 32'(pc_out), 32'(START));
    chk("R1 ir", 32'(ir_out), 32'h0);
    chk("R1 ac", 32'(ac_out), 32'h0);
    chk("R1 flags", {29'd0, halted, illegal, overflow}, 32'h0);
    chk("R1 we", 32'(mem_we), 32'h0);

    // Program 1: load, mixed-sign adds, zero cancel, stores, PC wrap, halt.
    put(12'hFFE, 16'h1010);
    put(12'hFFF, 16'h5011);
    put(12'h000, 16'h2020);
    put(12'h001, 16'h5012);
    put(12'h002, 16'h5013);
    put(12'h003, 16'h5014);
    put(12'h004, 16'h5015);
    put(12'h005, 16'h2021);
    put(12'h006, 16'h0000);
    put(12'h010, 16'h0005);
    put(12'h011, 16'h0007);
    put(12'h012, 16'h8014);
    put(12'h013, 16'h0008);
    put(12'h014, 16'h8003);
    put(12'h015, 16'h8004);
    run_until_halt();
    chk("R3 R5 stored sum", 32'(mem[12'h020]), 32'h000C);
    chk("R6 final ac", 32'(ac_out), 32'h8007);
    chk("R4 stored negative", 32'(mem[12'h021]), 32'h8007);
    chk("R8 pc wrapped", 32'(pc_out), 32'h006);
    chk("R9 no overflow", 32'(overflow), 32'h0);
    chk("R9 not illegal", 32'(illegal), 32'h0);
    pc_hold = pc_out;
    repeat (10) @(negedge clk);
    chk("R9 pc held", 32'(pc_out), 32'(pc_hold));
    chk("R9 still halted", 32'(halted), 32'h1);

    // Program 2: magnitude overflow to +0, sticky flag, illegal opcode.
    reset_core();
    clear_mem();
    chk("R1 pc after reset", 32'(pc_out), 32'(START));
    chk("R1 ac after reset", 32'(ac_out), 32'h0);
    put(12'hFFE, 16'h1010);
    put(12'hFFF, 16'h5011);
    put(12'h000, 16'h5012);
    put(12'h001, 16'h2020);
    put(12'h002, 16'h7000);
    put(12'h010, 16'h7FFF);
    put(12'h011, 16'h0001);
    put(12'h012, 16'h0003);
    run_until_halt();
    chk("R7 ac after wrap", 32'(ac_out), 32'h0003);
    chk("R7 sticky overflow", 32'(overflow), 32'h1);
    chk("R10 illegal", 32'(illegal), 32'h1);
    chk("R10 pc at illegal", 32'(pc_out), 32'h002);
    chk("R4 store after wrap", 32'(mem[12'h020]), 32'h0003);
    repeat (5) @(negedge clk);
    chk("R9 illegal halt holds", 32'(pc_out), 32'h002);

    // Program 3: negative load, add of equal magnitudes with opposite sign.
    reset_core();
    clear_mem();
    put(12'hFFE, 16'h1010);
    put(12'hFFF, 16'h5011);
    put(12'h000, 16'h0000);
    put(12'h010, 16'h8123);
    put(12'h011, 16'h0123);
    run_until_halt();
    chk("R6 plus zero", 32'(ac_out), 32'h0000);
    chk("R9 halt pc", 32'(pc_out), 32'h000);

    comparing = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule